// File: doc/BRIEF.md
# Multi-Retire Reorder Buffer

This block is the in-order bookkeeping ring of a speculative out-of-order core. Up to three operations per cycle are allocated at the tail in program order. Each operation gets a slot index that travels with it to the execution units. Result buses return a slot index and a value, which mark that slot as written. From the head, up to three consecutive written slots per cycle are retired toward the architectural register file write port. A slot that is still waiting at the head holds back every younger slot, even slots whose results are already present.

Allocation is a valid/ready stream. The issue side raises one valid bit per lane, and the block accepts the whole group only in a cycle where `alloc_ready` is high. Valid lanes need not be contiguous, because indices are handed out in lane order to the valid lanes only. Retirement is also a valid/ready stream. The lane valids form a prefix from the head. When `ret_ready` is low nothing retires and the outputs hold. Result writeback and branch mispredict recovery are plain control inputs with no handshake. A mispredict names the slot of the branch. Every slot younger than the branch is dropped in that cycle, and the next allocation reuses the slot just after the branch.

A rename status table records, for each architectural register, the slot of its youngest pending producer. Lookup ports read this table.

Top module: `rob_multiretire`

## Requirements
- R1: After reset the buffer is empty: `ret_valid` is 0, every lookup misses, and `alloc_ready` is 1 for a request of three lanes.
- R2: The valid allocation lanes, taken in ascending lane order, receive consecutive slot indices starting at the tail. An index that passes DEPTH-1 wraps to 0.
- R3: `alloc_ready` is low, and nothing is allocated, when the free slot count is smaller than the number of valid lanes, or while `flush_valid` is high.
- R4: A writeback with slot index i marks slot i written with the supplied value only if slot i is occupied. A writeback to a free slot has no effect on any later allocation of that slot.
- R5: Retire lane k is valid only if lanes 0..k-1 are valid and slot head+k is occupied and written. Lane k presents that slot's index, destination, value and operation tag.
- R6: While the head slot is not written, `ret_valid` is 0, whatever the state of younger slots.
- R7: While `ret_ready` is low, nothing retires and the retire outputs hold their values.
- R8: A mispredict at slot b keeps the slots from the head through b, drops all younger slots, and makes b+1 (mod DEPTH) the next slot allocated. Allocation is refused in the cycle of the mispredict.
- R9: A lookup of register r hits with the slot of the youngest occupied producer of r. A retire clears the entry only if the entry still points at the retiring slot.
- R10: After a mispredict, a lookup returns the youngest surviving producer, or misses when no producer survives.
- R11: The buffer holds exactly DEPTH slots. With all slots occupied, a one-lane request sees `alloc_ready` low. After a full drain it accepts three lanes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | ALLOC_W | Per-lane allocation request |
| alloc_ready | output | 1 | Whole request group accepted this cycle |
| alloc_dst | input | ALLOC_W*REGW | Per-lane destination register |
| alloc_op | input | ALLOC_W*OPW | Per-lane operation tag |
| alloc_idx | output | ALLOC_W*IDXW | Slot index assigned to each lane |
| wb_valid | input | WB_W | Per-port result valid |
| wb_idx | input | WB_W*IDXW | Per-port slot index |
| wb_value | input | WB_W*DW | Per-port result value |
| ret_valid | output | RET_W | Per-lane retire valid (prefix from head) |
| ret_ready | input | 1 | Register file accepts retirement |
| ret_idx | output | RET_W*IDXW | Retiring slot index |
| ret_dst | output | RET_W*REGW | Retiring destination register |
| ret_value | output | RET_W*DW | Retiring result value |
| ret_op | output | RET_W*OPW | Retiring operation tag |
| flush_valid | input | 1 | Branch mispredict |
| flush_idx | input | IDXW | Slot of the mispredicted branch |
| lk_reg | input | LK_W*REGW | Lookup register per port |
| lk_hit | output | LK_W | Lookup has a pending producer |
| lk_idx | output | LK_W*IDXW | Slot of that producer |

## Verification
The allocation indices and `alloc_ready` are combinational from the current tail, the occupancy and the request, so the bench reads them in the cycle it drives the request. Retire outputs come from registered slot state. A writeback or a head advance becomes visible on the first clock edge after it, so the bench checks these outputs one cycle after the stimulus. Lookup results come from the registered table and change one edge after the allocation, retire or mispredict that alters them. The bench drives each input just after a rising edge and samples one time unit later, before the next edge.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic {ST_ISSUED = 1'b0, ST_WRITTEN = 1'b1} rob_state_e;
endpackage

// File: rtl/rob_alloc.sv
module rob_alloc #(
  parameter int DEPTH   = 40,
  parameter int ALLOC_W = 3,
  parameter int IDXW    = 6,
  parameter int CNTW    = 6,
  parameter int LANEW   = 2
) (
  input  logic [IDXW-1:0]         tail,
  input  logic [CNTW-1:0]         count,
  input  logic [ALLOC_W-1:0]      alloc_valid,
  input  logic                    flush_valid,
  output logic [ALLOC_W*IDXW-1:0] alloc_idx,
  output logic [LANEW-1:0]        alloc_n,
  output logic                    alloc_ready,
  output logic                    alloc_fire
);
  function automatic logic [IDXW-1:0] ring_add(input logic [IDXW-1:0] base,
                                               input logic [CNTW-1:0] off);
    logic [CNTW:0] sum;
    sum = {{(CNTW+1-IDXW){1'b0}}, base} + {1'b0, off};
    if (sum >= (CNTW+1)'(DEPTH)) sum = sum - (CNTW+1)'(DEPTH);
    return sum[IDXW-1:0];
  endfunction

  logic [CNTW-1:0] free_slots;

  // Valid lanes take consecutive slots in lane order.
  always_comb begin
    logic [LANEW-1:0] pos;
    pos = '0;
    for (int i = 0; i < ALLOC_W; i++) begin
      alloc_idx[i*IDXW +: IDXW] = ring_add(tail, CNTW'(pos));
      pos = pos + LANEW'(alloc_valid[i]);
    end
    alloc_n = pos;
  end

  assign free_slots  = CNTW'(DEPTH) - count;
  assign alloc_ready = !flush_valid && (free_slots >= CNTW'(alloc_n));
  assign alloc_fire  = alloc_ready && (alloc_n != '0);
endmodule

// File: rtl/rob_retire.sv
module rob_retire #(
  parameter int DEPTH = 40,
  parameter int RET_W = 3,
  parameter int IDXW  = 6,
  parameter int CNTW  = 6,
  parameter int RLW   = 2
) (
  input  logic [IDXW-1:0]       head,
  input  logic [CNTW-1:0]       count,
  input  logic [DEPTH-1:0]      done_vec,
  input  logic                  flush_valid,
  input  logic                  ret_ready,
  output logic [RET_W-1:0]      ret_valid,
  output logic [RET_W*IDXW-1:0] ret_idx,
  output logic [RET_W-1:0]      ret_fire,
  output logic [RLW-1:0]        ret_n
);
  function automatic logic [IDXW-1:0] ring_add(input logic [IDXW-1:0] base,
                                               input logic [CNTW-1:0] off);
    logic [CNTW:0] sum;
    sum = {{(CNTW+1-IDXW){1'b0}}, base} + {1'b0, off};
    if (sum >= (CNTW+1)'(DEPTH)) sum = sum - (CNTW+1)'(DEPTH);
    return sum[IDXW-1:0];
  endfunction

  // A lane retires only if every older lane retires too.
  always_comb begin
    logic            chain;
    logic [IDXW-1:0] idx;
    chain = !flush_valid;
    for (int k = 0; k < RET_W; k++) begin
      idx = ring_add(head, CNTW'(k));
      chain = chain && (count > CNTW'(k)) && done_vec[idx];
      ret_valid[k] = chain;
      ret_idx[k*IDXW +: IDXW] = idx;
    end
  end

  assign ret_fire = ret_valid & {RET_W{ret_ready}};

  always_comb begin
    ret_n = '0;
    for (int k = 0; k < RET_W; k++) ret_n = ret_n + RLW'(ret_fire[k]);
  end
endmodule

// File: rtl/rob_regstat.sv
module rob_regstat #(
  parameter int NARCH   = 32,
  parameter int DEPTH   = 40,
  parameter int ALLOC_W = 3,
  parameter int RET_W   = 3,
  parameter int LK_W    = 2,
  parameter int IDXW    = 6,
  parameter int CNTW    = 6,
  parameter int REGW    = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc_fire,
  input  logic [ALLOC_W-1:0]      alloc_valid,
  input  logic [ALLOC_W*REGW-1:0] alloc_dst,
  input  logic [ALLOC_W*IDXW-1:0] alloc_idx,
  input  logic [RET_W-1:0]        ret_fire,
  input  logic [RET_W*REGW-1:0]   ret_dst,
  input  logic [RET_W*IDXW-1:0]   ret_idx,
  input  logic                    flush_valid,
  input  logic [IDXW-1:0]         head,
  input  logic [DEPTH-1:0]        keep_vec,
  input  logic [DEPTH*REGW-1:0]   ent_dst,
  input  logic [DEPTH-1:0]        busy_vec,
  input  logic [LK_W*REGW-1:0]    lk_reg,
  output logic [LK_W-1:0]         lk_hit,
  output logic [LK_W*IDXW-1:0]    lk_idx
);
  function automatic logic [IDXW-1:0] ring_add(input logic [IDXW-1:0] base,
                                               input logic [CNTW-1:0] off);
    logic [CNTW:0] sum;
    sum = {{(CNTW+1-IDXW){1'b0}}, base} + {1'b0, off};
    if (sum >= (CNTW+1)'(DEPTH)) sum = sum - (CNTW+1)'(DEPTH);
    return sum[IDXW-1:0];
  endfunction

  logic [NARCH-1:0] map_vld;
  logic [IDXW-1:0]  map_idx [NARCH];
  logic [NARCH-1:0] reb_vld;
  logic [IDXW-1:0]  reb_idx [NARCH];

  // Recovery: walk surviving slots oldest to youngest; the last match wins.
  always_comb begin
    logic [IDXW-1:0] e;
    for (int r = 0; r < NARCH; r++) begin
      reb_vld[r] = 1'b0;
      reb_idx[r] = '0;
      for (int off = 0; off < DEPTH; off++) begin
        e = ring_add(head, CNTW'(off));
        if (keep_vec[e] && ent_dst[e*REGW +: REGW] == REGW'(r)) begin
          reb_vld[r] = 1'b1;
          reb_idx[r] = e;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_vld <= '0;
      for (int r = 0; r < NARCH; r++) map_idx[r] <= '0;
    end else if (flush_valid) begin
      map_vld <= reb_vld;
      for (int r = 0; r < NARCH; r++) map_idx[r] <= reb_idx[r];
    end else begin
      for (int k = 0; k < RET_W; k++) begin
        if (ret_fire[k] && map_vld[ret_dst[k*REGW +: REGW]] &&
            map_idx[ret_dst[k*REGW +: REGW]] == ret_idx[k*IDXW +: IDXW])
          map_vld[ret_dst[k*REGW +: REGW]] <= 1'b0;
      end
      for (int i = 0; i < ALLOC_W; i++) begin
        if (alloc_fire && alloc_valid[i]) begin
          map_vld[alloc_dst[i*REGW +: REGW]] <= 1'b1;
          map_idx[alloc_dst[i*REGW +: REGW]] <= alloc_idx[i*IDXW +: IDXW];
        end
      end
    end
  end

  for (genvar p = 0; p < LK_W; p++) begin : g_lk
    assign lk_hit[p]                = map_vld[lk_reg[p*REGW +: REGW]];
    assign lk_idx[p*IDXW +: IDXW]   = map_idx[lk_reg[p*REGW +: REGW]];

    AST_LK_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit[p] |-> busy_vec[lk_idx[p*IDXW +: IDXW]]);  // R9
  end
endmodule

// File: rtl/rob_multiretire.sv
module rob_multiretire #(
  parameter int DEPTH   = 40,
  parameter int NARCH   = 32,
  parameter int DW      = 32,
  parameter int OPW     = 8,
  parameter int ALLOC_W = 3,
  parameter int RET_W   = 3,
  parameter int WB_W    = 2,
  parameter int LK_W    = 2,
  localparam int IDXW   = $clog2(DEPTH),
  localparam int CNTW   = $clog2(DEPTH + 1),
  localparam int REGW   = $clog2(NARCH),
  localparam int LANEW  = $clog2(ALLOC_W + 1),
  localparam int RLW    = $clog2(RET_W + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ALLOC_W-1:0]      alloc_valid,
  output logic                    alloc_ready,
  input  logic [ALLOC_W*REGW-1:0] alloc_dst,
  input  logic [ALLOC_W*OPW-1:0]  alloc_op,
  output logic [ALLOC_W*IDXW-1:0] alloc_idx,
  input  logic [WB_W-1:0]         wb_valid,
  input  logic [WB_W*IDXW-1:0]    wb_idx,
  input  logic [WB_W*DW-1:0]      wb_value,
  output logic [RET_W-1:0]        ret_valid,
  input  logic                    ret_ready,
  output logic [RET_W*IDXW-1:0]   ret_idx,
  output logic [RET_W*REGW-1:0]   ret_dst,
  output logic [RET_W*DW-1:0]     ret_value,
  output logic [RET_W*OPW-1:0]    ret_op,
  input  logic                    flush_valid,
  input  logic [IDXW-1:0]         flush_idx,
  input  logic [LK_W*REGW-1:0]    lk_reg,
  output logic [LK_W-1:0]         lk_hit,
  output logic [LK_W*IDXW-1:0]    lk_idx
);
  import rob_pkg::*;

  function automatic logic [IDXW-1:0] ring_add(input logic [IDXW-1:0] base,
                                               input logic [CNTW-1:0] off);
    logic [CNTW:0] sum;
    sum = {{(CNTW+1-IDXW){1'b0}}, base} + {1'b0, off};
    if (sum >= (CNTW+1)'(DEPTH)) sum = sum - (CNTW+1)'(DEPTH);
    return sum[IDXW-1:0];
  endfunction

  function automatic logic [CNTW-1:0] ring_dist(input logic [IDXW-1:0] from,
                                                input logic [IDXW-1:0] to);
    if (to >= from) return CNTW'(to - from);
    return CNTW'(DEPTH) - CNTW'(from - to);
  endfunction

  logic [DEPTH-1:0] busy_q;
  rob_state_e       state_q [DEPTH];
  logic [REGW-1:0]  dst_q   [DEPTH];
  logic [DW-1:0]    val_q   [DEPTH];
  logic [OPW-1:0]   op_q    [DEPTH];
  logic [IDXW-1:0]  head_q, tail_q;
  logic [CNTW-1:0]  count_q;

  logic [DEPTH-1:0]      done_vec, keep_vec;
  logic [DEPTH*REGW-1:0] dst_flat;
  logic [CNTW-1:0]       branch_off;
  logic [LANEW-1:0]      alloc_n;
  logic                  alloc_fire;
  logic [RET_W-1:0]      ret_fire;
  logic [RLW-1:0]        ret_n;

  assign branch_off = ring_dist(head_q, flush_idx);

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    assign done_vec[e] = busy_q[e] && (state_q[e] == ST_WRITTEN);
    assign keep_vec[e] = busy_q[e] && (ring_dist(head_q, IDXW'(e)) <= branch_off);
    assign dst_flat[e*REGW +: REGW] = dst_q[e];
  end

  rob_alloc #(.DEPTH(DEPTH), .ALLOC_W(ALLOC_W), .IDXW(IDXW), .CNTW(CNTW),
              .LANEW(LANEW)) u_alloc (
    .tail(tail_q), .count(count_q), .alloc_valid(alloc_valid),
    .flush_valid(flush_valid), .alloc_idx(alloc_idx), .alloc_n(alloc_n),
    .alloc_ready(alloc_ready), .alloc_fire(alloc_fire));

  rob_retire #(.DEPTH(DEPTH), .RET_W(RET_W), .IDXW(IDXW), .CNTW(CNTW),
               .RLW(RLW)) u_retire (
    .head(head_q), .count(count_q), .done_vec(done_vec),
    .flush_valid(flush_valid), .ret_ready(ret_ready), .ret_valid(ret_valid),
    .ret_idx(ret_idx), .ret_fire(ret_fire), .ret_n(ret_n));

  rob_regstat #(.NARCH(NARCH), .DEPTH(DEPTH), .ALLOC_W(ALLOC_W), .RET_W(RET_W),
                .LK_W(LK_W), .IDXW(IDXW), .CNTW(CNTW), .REGW(REGW)) u_regstat (
    .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire), .alloc_valid(alloc_valid),
    .alloc_dst(alloc_dst), .alloc_idx(alloc_idx), .ret_fire(ret_fire),
    .ret_dst(ret_dst), .ret_idx(ret_idx), .flush_valid(flush_valid),
    .head(head_q), .keep_vec(keep_vec), .ent_dst(dst_flat), .busy_vec(busy_q),
    .lk_reg(lk_reg), .lk_hit(lk_hit), .lk_idx(lk_idx));

  for (genvar k = 0; k < RET_W; k++) begin : g_ret
    assign ret_dst[k*REGW +: REGW] = dst_q[ret_idx[k*IDXW +: IDXW]];
    assign ret_value[k*DW +: DW]   = val_q[ret_idx[k*IDXW +: IDXW]];
    assign ret_op[k*OPW +: OPW]    = op_q[ret_idx[k*IDXW +: IDXW]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
      for (int e = 0; e < DEPTH; e++) begin
        state_q[e] <= ST_ISSUED;
        dst_q[e]   <= '0;
        val_q[e]   <= '0;
        op_q[e]    <= '0;
      end
    end else begin
      // Results land only in occupied slots.
      for (int p = 0; p < WB_W; p++) begin
        if (wb_valid[p] && wb_idx[p*IDXW +: IDXW] < IDXW'(DEPTH) &&
            busy_q[wb_idx[p*IDXW +: IDXW]]) begin
          state_q[wb_idx[p*IDXW +: IDXW]] <= ST_WRITTEN;
          val_q[wb_idx[p*IDXW +: IDXW]]   <= wb_value[p*DW +: DW];
        end
      end
      if (alloc_fire) begin
        for (int i = 0; i < ALLOC_W; i++) begin
          if (alloc_valid[i]) begin
            busy_q[alloc_idx[i*IDXW +: IDXW]]  <= 1'b1;
            state_q[alloc_idx[i*IDXW +: IDXW]] <= ST_ISSUED;
            dst_q[alloc_idx[i*IDXW +: IDXW]]   <= alloc_dst[i*REGW +: REGW];
            op_q[alloc_idx[i*IDXW +: IDXW]]    <= alloc_op[i*OPW +: OPW];
          end
        end
      end
      for (int k = 0; k < RET_W; k++) begin
        if (ret_fire[k]) busy_q[ret_idx[k*IDXW +: IDXW]] <= 1'b0;
      end
      if (flush_valid) begin
        for (int e = 0; e < DEPTH; e++) begin
          if (!keep_vec[e]) busy_q[e] <= 1'b0;
        end
        tail_q  <= ring_add(flush_idx, CNTW'(1));
        count_q <= branch_off + CNTW'(1);
      end else begin
        if (alloc_fire) tail_q <= ring_add(tail_q, CNTW'(alloc_n));
        count_q <= count_q + (alloc_fire ? CNTW'(alloc_n) : '0) - CNTW'(ret_n);
      end
      head_q <= ring_add(head_q, CNTW'(ret_n));
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNTW'(DEPTH));  // R11
  AST_BUSY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    CNTW'($countones(busy_q)) == count_q);  // R11
  AST_FLUSH_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> count_q <= $past(count_q));  // R8
  AST_RET_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid[0] && ret_ready) |=> head_q != $past(head_q));  // R5
  AST_STALL_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    ((alloc_valid != '0) && !alloc_ready && !flush_valid) |=> tail_q == $past(tail_q));  // R3
endmodule

// File: tb/rob_multiretire_bench.sv
module rob_multiretire_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 40, NARCH = 32, DW = 32, OPW = 8;
  localparam int ALLOC_W = 3, RET_W = 3, WB_W = 2, LK_W = 2;
  localparam int IDXW = $clog2(DEPTH), REGW = $clog2(NARCH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ALLOC_W-1:0]      alloc_valid = '0;
  logic                    alloc_ready;
  logic [ALLOC_W*REGW-1:0] alloc_dst = '0;
  logic [ALLOC_W*OPW-1:0]  alloc_op = '0;
  logic [ALLOC_W*IDXW-1:0] alloc_idx;
  logic [WB_W-1:0]         wb_valid = '0;
  logic [WB_W*IDXW-1:0]    wb_idx = '0;
  logic [WB_W*DW-1:0]      wb_value = '0;
  logic [RET_W-1:0]        ret_valid;
  logic                    ret_ready = 1'b0;
  logic [RET_W*IDXW-1:0]   ret_idx;
  logic [RET_W*REGW-1:0]   ret_dst;
  logic [RET_W*DW-1:0]     ret_value;
  logic [RET_W*OPW-1:0]    ret_op;
  logic                    flush_valid = 1'b0;
  logic [IDXW-1:0]         flush_idx = '0;
  logic [LK_W*REGW-1:0]    lk_reg = '0;
  logic [LK_W-1:0]         lk_hit;
  logic [LK_W*IDXW-1:0]    lk_idx;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rob_multiretire u_rob_multiretire (.*);

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    alloc_valid = '0; wb_valid = '0; flush_valid = 1'b0;
  endtask

  task automatic put_alloc(input int lane, input int dst, input int op);
    alloc_valid[lane] = 1'b1;
    alloc_dst[lane*REGW +: REGW] = REGW'(dst);
    alloc_op[lane*OPW +: OPW] = OPW'(op);
  endtask

  task automatic put_wb(input int port, input int idx, input int val);
    wb_valid[port] = 1'b1;
    wb_idx[port*IDXW +: IDXW] = IDXW'(idx);
    wb_value[port*DW +: DW] = DW'(val);
  endtask

  function automatic int a_idx(input int l); return int'(alloc_idx[l*IDXW +: IDXW]); endfunction
  function automatic int r_idx(input int l); return int'(ret_idx[l*IDXW +: IDXW]); endfunction
  function automatic int r_dst(input int l); return int'(ret_dst[l*REGW +: REGW]); endfunction
  function automatic int r_val(input int l); return int'(ret_value[l*DW +: DW]); endfunction
  function automatic int r_op(input int l);  return int'(ret_op[l*OPW +: OPW]); endfunction
  function automatic int l_idx(input int p); return int'(lk_idx[p*IDXW +: IDXW]); endfunction

  task automatic look(input int r0, input int r1);
    lk_reg[0 +: REGW] = REGW'(r0);
    lk_reg[REGW +: REGW] = REGW'(r1);
    #1;
  endtask

  task automatic t_reset();
    alloc_valid = 3'b111; #1;
    chk("R1", "alloc_ready", int'(alloc_ready), 1);
    chk("R1", "ret_valid", int'(ret_valid), 0);
    look(1, 2);
    chk("R1", "lk_hit", int'(lk_hit), 0);
    idle();
  endtask

  task automatic t_alloc();
    put_alloc(0, 1, 10); put_alloc(1, 2, 11); put_alloc(2, 3, 12); #1;
    chk("R2", "ready", int'(alloc_ready), 1);
    chk("R2", "idx lane0", a_idx(0), 0);
    chk("R2", "idx lane1", a_idx(1), 1);
    chk("R2", "idx lane2", a_idx(2), 2);
    tick(); idle();
    put_alloc(0, 1, 13); put_alloc(2, 5, 14); #1;
    chk("R2", "sparse lane0", a_idx(0), 3);
    chk("R2", "sparse lane2", a_idx(2), 4);
    tick(); idle();
    look(1, 2);
    chk("R9", "lk reg1 hit", int'(lk_hit[0]), 1);
    chk("R9", "lk reg1 youngest", l_idx(0), 3);
    chk("R9", "lk reg2 idx", l_idx(1), 1);
  endtask

  task automatic t_inorder();
    put_wb(0, 1, 'h22); put_wb(1, 2, 'h33);
    tick(); idle(); #1;
    chk("R6", "head pending", int'(ret_valid), 0);
    put_wb(0, 0, 'h11);
    tick(); idle(); #1;
    chk("R5", "three lanes", int'(ret_valid), 7);
    chk("R5", "val0", r_val(0), 'h11);
    chk("R5", "val1", r_val(1), 'h22);
    chk("R5", "val2", r_val(2), 'h33);
    chk("R5", "dst2", r_dst(2), 3);
    chk("R5", "op1", r_op(1), 11);
    tick();
    chk("R7", "held valid", int'(ret_valid), 7);
    chk("R7", "held val0", r_val(0), 'h11);
    ret_ready = 1'b1;
    tick();
    chk("R6", "head 3 pending", int'(ret_valid), 0);
    look(1, 2);
    chk("R9", "reg1 kept", l_idx(0), 3);
    chk("R9", "reg2 cleared", int'(lk_hit[1]), 0);
    put_wb(0, 4, 'h55); put_wb(1, 5, 'h99);
    tick(); idle(); #1;
    chk("R6", "younger written, head not", int'(ret_valid), 0);
    put_wb(0, 3, 'h44);
    tick(); idle(); #1;
    chk("R5", "two lanes", int'(ret_valid), 3);
    chk("R5", "idx0", r_idx(0), 3);
    chk("R5", "val0", r_val(0), 'h44);
    chk("R5", "dst1", r_dst(1), 5);
    chk("R5", "val1", r_val(1), 'h55);
    put_alloc(0, 6, 15); #1;
    chk("R2", "next idx", a_idx(0), 5);
    tick(); idle(); #1;
    chk("R4", "free-slot wb ignored", int'(ret_valid), 0);
    look(1, 6);
    chk("R9", "reg1 cleared on match", int'(lk_hit[0]), 0);
    put_wb(0, 5, 'h66);
    tick(); idle(); #1;
    chk("R4", "written", int'(ret_valid), 1);
    chk("R4", "value", r_val(0), 'h66);
    tick();
  endtask

  task automatic t_flush();
    ret_ready = 1'b0;
    put_alloc(0, 7, 20); put_alloc(1, 8, 21); put_alloc(2, 7, 22); #1;
    chk("R2", "group idx0", a_idx(0), 6);
    tick(); idle();
    put_alloc(0, 9, 23); put_alloc(1, 7, 24); put_alloc(2, 9, 25);
    tick(); idle();
    look(7, 9);
    chk("R9", "reg7", l_idx(0), 10);
    chk("R9", "reg9", l_idx(1), 11);
    flush_valid = 1'b1; flush_idx = 8; put_alloc(0, 3, 26); #1;
    chk("R3", "no alloc in flush", int'(alloc_ready), 0);
    tick(); idle();
    look(7, 9);
    chk("R10", "reg7 survivor", l_idx(0), 8);
    chk("R10", "reg7 hit", int'(lk_hit[0]), 1);
    chk("R10", "reg9 gone", int'(lk_hit[1]), 0);
    put_alloc(0, 12, 27); #1;
    chk("R8", "reuse after branch", a_idx(0), 9);
    tick(); idle();
    put_wb(0, 10, 'h77); put_wb(1, 6, 'h60);
    tick(); idle();
    put_wb(0, 7, 'h70); put_wb(1, 8, 'h80);
    tick(); idle();
    put_wb(0, 9, 'h90);
    tick(); idle();
    ret_ready = 1'b1; #1;
    chk("R8", "kept lanes", int'(ret_valid), 7);
    chk("R8", "branch idx", r_idx(2), 8);
    chk("R8", "branch val", r_val(2), 'h80);
    tick();
    chk("R8", "younger dropped", int'(ret_valid), 1);
    chk("R8", "new entry", r_val(0), 'h90);
    tick();
    chk("R8", "empty", int'(ret_valid), 0);
  endtask

  task automatic t_full();
    ret_ready = 1'b0;
    for (int g = 0; g < 13; g++) begin
      for (int l = 0; l < 3; l++) put_alloc(l, (3*g + l) % 32, 3*g + l);
      #1;
      for (int l = 0; l < 3; l++) chk("R2", "wrap idx", a_idx(l), (10 + 3*g + l) % 40);
      tick(); idle();
    end
    alloc_valid = 3'b111; #1;
    chk("R3", "free 1 of 3", int'(alloc_ready), 0);
    idle();
    put_alloc(0, 39 % 32, 39); #1;
    chk("R11", "last slot ready", int'(alloc_ready), 1);
    chk("R11", "last slot idx", a_idx(0), 9);
    tick(); idle();
    alloc_valid = 3'b001; #1;
    chk("R11", "full", int'(alloc_ready), 0);
    tick(); idle();
    for (int p = 0; p < 20; p++) begin
      put_wb(0, 2*p, 1000 + 2*p); put_wb(1, 2*p + 1, 1001 + 2*p);
      tick(); idle();
    end
    ret_ready = 1'b1;
    for (int c = 0; c < 14; c++) begin
      #1;
      chk("R11", "drain lanes", int'(ret_valid), (c < 13) ? 7 : 1);
      chk("R11", "drain idx", r_idx(0), (10 + 3*c) % 40);
      chk("R11", "drain val", r_val(0), 1000 + (10 + 3*c) % 40);
      chk("R11", "drain dst", r_dst(0), (3*c) % 32);
      tick();
    end
    chk("R11", "drained", int'(ret_valid), 0);
    alloc_valid = 3'b111; #1;
    chk("R11", "accepts again", int'(alloc_ready), 1);
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    t_reset();
    t_alloc();
    t_inorder();
    t_flush();
    t_full();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule